// File: doc/BRIEF.md
# Two-Phase Pulse Up/Down Counter

This block counts transitions on two phase-shifted pulse inputs, such as the A and B tracks of an incremental encoder. Both inputs are first brought into the system clock domain. Each change is then decoded into a count-up or count-down step. The result drives a 16-bit counter. A mode input chooses between plain up-counting and up/down counting. In up/down mode the phase order of the two inputs sets the direction, and every edge on either input counts once (4x decoding).

Entering up/down mode preloads the counter to mid-scale, so that travel in either direction has room before it wraps. When the counter wraps in either direction it reloads a fixed value and emits a single-cycle pulse. A downstream interrupt controller can take these pulses as raw events. If both phases change in the same cycle, the transition cannot be decoded. It is dropped and flagged. A run input gates counting without disturbing the held value.

Top module: `quad_pulse_counter`

## Requirements
- R1: After synchronous reset the count is 0x0000 and the overflow, underflow and error pulses are low.
- R2: Each phase input passes two synchronizer flops. A change driven between rising edges E0 and E1 reaches the count at edge E3 and is not yet visible after E2.
- R3: A rising edge of `dual_mode`, seen against its value one cycle earlier, loads the count with 0x7FFF. This takes priority over anything else in that cycle.
- R4: In up/down mode a change on phase A alone counts up when A's new level differs from B, and down otherwise. A change on phase B alone counts up when B's new level equals A, and down otherwise. The sequence 00→10→11→01→00, written as (A,B), therefore counts up.
- R5: In up/down mode an up step from 0xFFFF reloads 0x0000, and `ovf_pulse` is high for exactly the cycle in which 0x0000 first appears.
- R6: In up/down mode a down step from 0x0000 reloads 0xFFFF, and `unf_pulse` is high for exactly the cycle in which 0xFFFF first appears.
- R7: In up/down mode a change on both phases in the same cycle leaves the count unchanged and raises `err_pulse` for one cycle. Overflow, underflow and error never coincide.
- R8: With `dual_mode` low, only a rising edge on phase A counts, always upward. Phase B, falling A edges and simultaneous changes have no effect and raise no error. An up step from 0xFFFF gives 0x0000 with an `ovf_pulse`.
- R9: While `run_en` is low and no mode entry occurs, the count holds its value and no pulse is raised. Counting resumes from the held value when `run_en` returns high.
- R10: A decoded step that lands in the same cycle as a mode entry is discarded, and the count reads 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Counting enable |
| dual_mode | input | 1 | 1 selects up/down counting from two phases, 0 selects up-only |
| ph_a | input | 1 | Phase A pulse input, asynchronous |
| ph_b | input | 1 | Phase B pulse input, asynchronous |
| count | output | 16 | Current counter value |
| ovf_pulse | output | 1 | One-cycle pulse on upward wrap |
| unf_pulse | output | 1 | One-cycle pulse on downward wrap |
| err_pulse | output | 1 | One-cycle pulse on an undecodable transition |

## Verification
Mode entry and a decoded phase step can arrive at the counter register in the same clock cycle. The preload must win, and the step must vanish without a wrap pulse. The bench provokes this by changing one phase and then raising `dual_mode` exactly two negative edges later, so that both reach the counter at one rising edge. It then expects 0x7FFF with no pulse counted. The overflow and underflow reloads are reached by stepping the counter one phase change per clock across half the range, and each reload is judged by the value and the cumulative pulse totals.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    typedef struct packed {
        step_e dir;      // decoded direction in up/down mode
        logic  illegal;  // both phases moved together
        logic  a_rise;   // rising edge of phase A (up-only mode)
    } step_t;

    // Classify one sampled transition of the phase pair.
    function automatic step_t classify(
        input logic a_old,
        input logic b_old,
        input logic a_new,
        input logic b_new
    );
        step_t r;
        logic  a_chg;
        logic  b_chg;
        a_chg     = a_old ^ a_new;
        b_chg     = b_old ^ b_new;
        r.dir     = STEP_NONE;
        r.illegal = a_chg & b_chg;
        r.a_rise  = ~a_old & a_new;
        if (a_chg && !b_chg) begin
            r.dir = (a_new != b_new) ? STEP_UP : STEP_DOWN;
        end else if (b_chg && !a_chg) begin
            r.dir = (b_new == a_new) ? STEP_UP : STEP_DOWN;
        end
        return r;
    endfunction

endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/qpc_decode.sv
module qpc_decode
    import qpc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  a_s,
    input  logic  b_s,
    output step_t step
);
    logic a_q;
    logic b_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
        end else begin
            a_q <= a_s;
            b_q <= b_s;
        end
    end

    always_comb begin
        step = classify(a_q, b_q, a_s, b_s);
    end
endmodule

// File: rtl/qpc_count.sv
module qpc_count
    import qpc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             dual_mode,
    input  step_t            step,
    output logic [CNT_W-1:0] cnt,
    output logic             mode_q,
    output logic             ovf,
    output logic             unf,
    output logic             err
);
    localparam logic [CNT_W-1:0] CNT_MAX    = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_MIN    = '0;
    localparam logic [CNT_W-1:0] PRELOAD    = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] OVF_RELOAD = '0;
    localparam logic [CNT_W-1:0] UNF_RELOAD = {CNT_W{1'b1}};

    logic entry;
    logic do_up;
    logic do_down;

    always_comb begin
        entry   = dual_mode & ~mode_q;
        do_up   = 1'b0;
        do_down = 1'b0;
        if (run_en && !entry) begin
            if (dual_mode) begin
                do_up   = (step.dir == STEP_UP);
                do_down = (step.dir == STEP_DOWN);
            end else begin
                do_up   = step.a_rise;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            mode_q <= 1'b0;
            ovf    <= 1'b0;
            unf    <= 1'b0;
            err    <= 1'b0;
        end else begin
            mode_q <= dual_mode;
            ovf    <= 1'b0;
            unf    <= 1'b0;
            err    <= run_en & dual_mode & ~entry & step.illegal;
            if (entry) begin
                cnt <= PRELOAD;
            end else if (do_up) begin
                if (cnt == CNT_MAX) begin
                    cnt <= OVF_RELOAD;
                    ovf <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (do_down) begin
                if (cnt == CNT_MIN) begin
                    cnt <= UNF_RELOAD;
                    unf <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/quad_pulse_counter.sv
module quad_pulse_counter
    import qpc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             dual_mode,
    input  logic             ph_a,
    input  logic             ph_b,
    output logic [CNT_W-1:0] count,
    output logic             ovf_pulse,
    output logic             unf_pulse,
    output logic             err_pulse
);
    localparam int PH_W = 2;

    logic [PH_W-1:0] ph_sync;
    step_t           step;
    logic            mode_q;

    qpc_sync #(.WIDTH(PH_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ph_b, ph_a}),
        .dout (ph_sync)
    );

    qpc_decode u_decode (
        .clk  (clk),
        .rst  (rst),
        .a_s  (ph_sync[0]),
        .b_s  (ph_sync[1]),
        .step (step)
    );

    qpc_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .dual_mode (dual_mode),
        .step      (step),
        .cnt       (count),
        .mode_q    (mode_q),
        .ovf       (ovf_pulse),
        .unf       (unf_pulse),
        .err       (err_pulse)
    );
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             run_en,
    input logic             dual_mode,
    input logic             mode_q,
    input logic [CNT_W-1:0] count,
    input logic             ovf_pulse,
    input logic             unf_pulse,
    input logic             err_pulse
);
    localparam logic [CNT_W-1:0] MID = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    // R3
    entry_preload_chk: assert property (@(posedge clk) disable iff (rst)
        (dual_mode && !mode_q) |=> (count == MID));

    // R5
    ovf_reload_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> (count == '0 && $past(count) == TOP));

    // R6
    unf_reload_chk: assert property (@(posedge clk) disable iff (rst)
        unf_pulse |-> (count == TOP && $past(count) == '0));

    // R7
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> (count == $past(count)));

    // R7
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ovf_pulse, unf_pulse, err_pulse}));

    // R9
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !(dual_mode && !mode_q)) |=>
            ($stable(count) && !ovf_pulse && !unf_pulse && !err_pulse));
endmodule

bind quad_pulse_counter qpc_checker #(.CNT_W(CNT_W)) u_qpc_checker (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .dual_mode (dual_mode),
    .mode_q    (mode_q),
    .count     (count),
    .ovf_pulse (ovf_pulse),
    .unf_pulse (unf_pulse),
    .err_pulse (err_pulse)
);

// File: tb/test_quad_pulse_counter.sv
module test_quad_pulse_counter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic        dual_mode = 1'b0;
    logic        ph_a = 1'b0;
    logic        ph_b = 1'b0;
    logic [15:0] count;
    logic        ovf_pulse, unf_pulse, err_pulse;

    int checks = 0;
    int errors = 0;
    int seen_ovf = 0, seen_unf = 0, seen_err = 0;
    int exp_ovf = 0, exp_unf = 0, exp_err = 0;
    logic [15:0] exp_cnt = 16'h0000;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    quad_pulse_counter i_quad_pulse_counter (
        .clk(clk), .rst(rst), .run_en(run_en), .dual_mode(dual_mode),
        .ph_a(ph_a), .ph_b(ph_b), .count(count),
        .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse), .err_pulse(err_pulse)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (ovf_pulse) seen_ovf++;
            if (unf_pulse) seen_unf++;
            if (err_pulse) seen_err++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk({req, " count"}, int'(count), int'(exp_cnt));
        chk({req, " ovf"}, seen_ovf, exp_ovf);
        chk({req, " unf"}, seen_unf, exp_unf);
        chk({req, " err"}, seen_err, exp_err);
    endtask

    // Expected effect of moving the phases from (ph_a,ph_b) to (na,nb).
    function automatic void model(input logic na, input logic nb);
        bit ca = (na != ph_a);
        bit cb = (nb != ph_b);
        int dir = 0;
        if (!run_en) return;
        if (!dual_mode) begin
            if (!ph_a && na) dir = 1;
        end else if (ca && cb) begin
            exp_err++;
        end else if (ca) begin
            dir = (na != ph_b) ? 1 : -1;
        end else if (cb) begin
            dir = (nb == ph_a) ? 1 : -1;
        end
        if (dir == 1) begin
            if (exp_cnt == 16'hFFFF) exp_ovf++;
            exp_cnt = exp_cnt + 16'd1;
        end else if (dir == -1) begin
            if (exp_cnt == 16'h0000 && dual_mode) exp_unf++;
            exp_cnt = exp_cnt - 16'd1;
        end
    endfunction

    task automatic drive(input logic na, input logic nb);
        @(negedge clk);
        model(na, nb);
        ph_a = na;
        ph_b = nb;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic set_mode(input logic d);
        @(negedge clk);
        if (d && !dual_mode) exp_cnt = 16'h7FFF;
        dual_mode = d;
    endtask

    // One legal quadrature step per clock in the chosen direction.
    task automatic sweep(input int n, input bit up);
        for (int i = 0; i < n; i++) begin
            if ((ph_a == ph_b) == up) drive(~ph_a, ph_b);
            else                      drive(ph_a, ~ph_b);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int sd;
        sd = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk_all("R1");

        // R8 up-only mode: A rise counts, B and A fall ignored
        run_en = 1'b1;
        drive(1'b1, 1'b0); settle(); chk_all("R8 a-rise");
        drive(1'b1, 1'b1); settle(); chk_all("R8 b-ignored");
        drive(1'b0, 1'b1); settle(); chk_all("R8 a-fall");
        drive(1'b1, 1'b0); settle(); chk_all("R8 both-no-err");
        for (int i = 0; i < 40; i++) begin
            drive(1'($urandom), 1'($urandom)); settle();
        end
        chk_all("R8 random");

        // R2 latency: visible at third edge, not second
        drive(1'b0, 1'b0); settle();
        @(negedge clk); model(1'b1, 1'b0); ph_a = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R2 not-yet", int'(count), int'(exp_cnt - 16'd1));
        @(negedge clk);
        chk("R2 arrived", int'(count), int'(exp_cnt));

        // R3 mode entry preload
        drive(1'b0, 1'b0); settle();
        set_mode(1'b1); settle(); chk_all("R3 entry");

        // R4 direction rules
        drive(1'b1, 1'b0); settle(); chk_all("R4 a-rise b-low up");
        drive(1'b1, 1'b1); settle(); chk_all("R4 b-rise a-high up");
        drive(1'b1, 1'b0); settle(); chk_all("R4 b-fall a-high down");
        drive(1'b0, 1'b0); settle(); chk_all("R4 a-fall b-low down");
        for (int i = 0; i < 300; i++) begin
            if ($urandom % 2) drive(~ph_a, ph_b);
            else              drive(ph_a, ~ph_b);
            if ($urandom % 3 == 0) settle();
        end
        settle(); chk_all("R4 random");

        // R7 illegal transition
        drive(~ph_a, ~ph_b); settle(); chk_all("R7 both-change");

        // R9 run low holds
        @(negedge clk); run_en = 1'b0;
        drive(~ph_a, ph_b); drive(ph_a, ~ph_b); settle();
        chk_all("R9 hold");
        @(negedge clk); run_en = 1'b1;
        drive(~ph_a, ph_b); settle(); chk_all("R9 resume");

        // R5/R6 wrap from mid-scale
        set_mode(1'b0); set_mode(1'b1); settle();
        sweep(32768, 1'b1); settle(); chk_all("R5 at-max");
        sweep(1, 1'b1); settle(); chk_all("R5 overflow");
        sweep(1, 1'b0); settle(); chk_all("R6 underflow");
        sweep(3, 1'b0); settle(); chk_all("R6 after");

        // R10 step and entry in the same cycle
        set_mode(1'b0); settle();
        @(negedge clk); ph_b = ~ph_b;
        @(negedge clk);
        @(negedge clk); dual_mode = 1'b1; exp_cnt = 16'h7FFF;
        settle(); chk_all("R10 entry-wins");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule